// File: doc/BRIEF.md
# Pipelined Constant-Twiddle Radix-2 Butterfly

This block computes one radix-2 butterfly step over complex operands. It takes a wide first operand A, a narrow second operand B and a fixed complex twiddle factor W, and returns both the sum A + W·B and the difference A − W·B. W is a parameter, so the multiplier only ever scales by a constant.

The block is fully pipelined with a fixed depth of three registers. It accepts a new operand pair on every clock and returns a new result pair on every clock. A valid strobe travels alongside the data, so the upstream logic can leave gaps in the stream. The complex product is spread over two registered stages: the four real products are formed first, then their difference and sum. A final stage performs the additions and subtractions with one guard bit of growth.

W is given as signed fixed point with `FRAC` fraction bits. The product is brought back to the scale of A by dropping those fraction bits, which rounds toward negative infinity. All arithmetic is two's complement. Default widths are 16-bit parts for A, 8-bit parts for B and W, and 17-bit output parts.

Top module: `twiddle_butterfly`

## Requirements
- R1: The result pair for the operands sampled on clock edge k is presented after edge k+3, and `out_vld` after edge k+3 equals `in_vld` sampled on edge k.
- R2: Real parts, with T_re = floor((W_re·b_re − W_im·b_im) / 2^FRAC): `y1_re` = `a_re` + T_re and `y2_re` = `a_re` − T_re.
- R3: Imaginary parts, with T_im = floor((W_re·b_im + W_im·b_re) / 2^FRAC): `y1_im` = `a_im` + T_im and `y2_im` = `a_im` − T_im.
- R4: The fraction bits are dropped by an arithmetic shift, so negative products round toward minus infinity (for example −1/64 becomes −1, not 0).
- R5: Each output part is one bit wider than an `a` part and never wraps, including when `a` is at full-scale negative (−32768) or full-scale positive (32767) and `b` takes any value.
- R6: Operands presented on consecutive clocks yield results on consecutive clocks, with no stall and no bubble.
- R7: A synchronous reset (`rst` high at a rising edge) clears every pipeline register, so after that edge all outputs read zero and `out_vld` is low. Operands in flight at that edge produce no valid result.
- R8: Cycles with `in_vld` low produce `out_vld` low exactly three edges later, while the data path keeps computing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Operands on the inputs are valid |
| a_re | input | 16 | Real part of the added operand, signed |
| a_im | input | 16 | Imaginary part of the added operand, signed |
| b_re | input | 8 | Real part of the operand multiplied by W, signed |
| b_im | input | 8 | Imaginary part of the operand multiplied by W, signed |
| out_vld | output | 1 | Result pair is valid |
| y1_re | output | 17 | Real part of A + W·B, signed |
| y1_im | output | 17 | Imaginary part of A + W·B, signed |
| y2_re | output | 17 | Real part of A − W·B, signed |
| y2_im | output | 17 | Imaginary part of A − W·B, signed |

## Verification
The hard case to reach is the largest product magnitude meeting a full-scale `a` in the same cycle, together with the floor rounding of negative products. Random stimulus rarely lands there. The bench therefore sweeps every one of the 65,536 values of `b` while `a` cycles through −32768, 32767, 0 and −1 interleaved with scrambled values, so each extreme of `b` meets each extreme of `a`. The valid strobe drops on a fixed stride during that sweep. A reset is also applied with valid operands still in flight, to show that they never emerge.

// File: rtl/bfly_pkg.sv
package bfly_pkg;

    function automatic int wider(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/bfly_delay.sv
module bfly_delay #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [DEPTH-1:0][WIDTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = din;
        for (int i = 1; i < DEPTH; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= pipe_d;
    end

    assign dout = pipe_q[DEPTH-1];
endmodule

// File: rtl/tw_cmul.sv
module tw_cmul #(
    parameter int X2_W  = 8,
    parameter int TW_W  = 8,
    parameter int FRAC  = 6,
    parameter logic signed [TW_W-1:0] W_RE = 45,
    parameter logic signed [TW_W-1:0] W_IM = -45,
    localparam int PROD_W = X2_W + TW_W,
    localparam int SUM_W  = PROD_W + 1,
    localparam int T_W    = SUM_W - FRAC
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic signed [X2_W-1:0] b_re,
    input  logic signed [X2_W-1:0] b_im,
    output logic signed [T_W-1:0]  t_re,
    output logic signed [T_W-1:0]  t_im
);
    typedef struct packed {
        logic signed [PROD_W-1:0] rr;
        logic signed [PROD_W-1:0] ii;
        logic signed [PROD_W-1:0] ri;
        logic signed [PROD_W-1:0] ir;
        logic signed [T_W-1:0]    t_re;
        logic signed [T_W-1:0]    t_im;
    } cm_t;

    cm_t cm_d, cm_q;
    logic signed [SUM_W-1:0] s_re, s_im;

    always_comb begin
        cm_d    = cm_q;
        // first registered stage: four real products
        cm_d.rr = W_RE * b_re;
        cm_d.ii = W_IM * b_im;
        cm_d.ri = W_RE * b_im;
        cm_d.ir = W_IM * b_re;
        // second registered stage: one subtract, one add, fraction dropped
        s_re    = {cm_q.rr[PROD_W-1], cm_q.rr} - {cm_q.ii[PROD_W-1], cm_q.ii};
        s_im    = {cm_q.ri[PROD_W-1], cm_q.ri} + {cm_q.ir[PROD_W-1], cm_q.ir};
        cm_d.t_re = s_re[SUM_W-1:FRAC];
        cm_d.t_im = s_im[SUM_W-1:FRAC];
    end

    always_ff @(posedge clk) begin
        if (rst) cm_q <= '0;
        else     cm_q <= cm_d;
    end

    assign t_re = cm_q.t_re;
    assign t_im = cm_q.t_im;
endmodule

// File: rtl/bfly_addsub.sv
module bfly_addsub #(
    parameter int X1_W = 16,
    parameter int T_W  = 11,
    parameter int Y_W  = 17
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic signed [X1_W-1:0] a_re,
    input  logic signed [X1_W-1:0] a_im,
    input  logic signed [T_W-1:0]  t_re,
    input  logic signed [T_W-1:0]  t_im,
    output logic signed [Y_W-1:0]  y1_re,
    output logic signed [Y_W-1:0]  y1_im,
    output logic signed [Y_W-1:0]  y2_re,
    output logic signed [Y_W-1:0]  y2_im
);
    typedef struct packed {
        logic signed [Y_W-1:0] y1_re;
        logic signed [Y_W-1:0] y1_im;
        logic signed [Y_W-1:0] y2_re;
        logic signed [Y_W-1:0] y2_im;
    } as_t;

    as_t as_d, as_q;

    always_comb begin
        as_d.y1_re = Y_W'(a_re) + Y_W'(t_re);
        as_d.y1_im = Y_W'(a_im) + Y_W'(t_im);
        as_d.y2_re = Y_W'(a_re) - Y_W'(t_re);
        as_d.y2_im = Y_W'(a_im) - Y_W'(t_im);
    end

    always_ff @(posedge clk) begin
        if (rst) as_q <= '0;
        else     as_q <= as_d;
    end

    assign y1_re = as_q.y1_re;
    assign y1_im = as_q.y1_im;
    assign y2_re = as_q.y2_re;
    assign y2_im = as_q.y2_im;
endmodule

// File: rtl/twiddle_butterfly.sv
module twiddle_butterfly
    import bfly_pkg::*;
#(
    parameter int X1_W = 16,
    parameter int X2_W = 8,
    parameter int TW_W = 8,
    parameter int FRAC = 6,
    parameter logic signed [TW_W-1:0] W_RE = 45,
    parameter logic signed [TW_W-1:0] W_IM = -45,
    localparam int T_W = X2_W + TW_W + 1 - FRAC,
    localparam int Y_W = wider(X1_W, T_W) + 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_vld,
    input  logic signed [X1_W-1:0] a_re,
    input  logic signed [X1_W-1:0] a_im,
    input  logic signed [X2_W-1:0] b_re,
    input  logic signed [X2_W-1:0] b_im,
    output logic                   out_vld,
    output logic signed [Y_W-1:0]  y1_re,
    output logic signed [Y_W-1:0]  y1_im,
    output logic signed [Y_W-1:0]  y2_re,
    output logic signed [Y_W-1:0]  y2_im
);
    localparam int MUL_STAGES = 2;
    localparam int ALL_STAGES = MUL_STAGES + 1;

    logic signed [T_W-1:0]    t_re, t_im;
    logic [2*X1_W-1:0]        a_late;
    logic [0:0]               vld_late;

    tw_cmul #(
        .X2_W (X2_W), .TW_W (TW_W), .FRAC (FRAC),
        .W_RE (W_RE), .W_IM (W_IM)
    ) u_cmul (
        .clk (clk), .rst (rst),
        .b_re (b_re), .b_im (b_im),
        .t_re (t_re), .t_im (t_im)
    );

    bfly_delay #(.WIDTH(2*X1_W), .DEPTH(MUL_STAGES)) u_a_dly (
        .clk (clk), .rst (rst), .din ({a_re, a_im}), .dout (a_late)
    );

    bfly_delay #(.WIDTH(1), .DEPTH(ALL_STAGES)) u_vld_dly (
        .clk (clk), .rst (rst), .din (in_vld), .dout (vld_late)
    );

    bfly_addsub #(.X1_W(X1_W), .T_W(T_W), .Y_W(Y_W)) u_addsub (
        .clk   (clk), .rst (rst),
        .a_re  (a_late[2*X1_W-1:X1_W]),
        .a_im  (a_late[X1_W-1:0]),
        .t_re  (t_re), .t_im (t_im),
        .y1_re (y1_re), .y1_im (y1_im),
        .y2_re (y2_re), .y2_im (y2_im)
    );

    assign out_vld = vld_late[0];
endmodule

// File: rtl/bfly_checker.sv
module bfly_checker #(
    parameter int X1_W = 16,
    parameter int T_W  = 11,
    parameter int Y_W  = 17
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   in_vld,
    input logic signed [X1_W-1:0] a_re,
    input logic signed [X1_W-1:0] a_im,
    input logic                   out_vld,
    input logic signed [Y_W-1:0]  y1_re,
    input logic signed [Y_W-1:0]  y1_im,
    input logic signed [Y_W-1:0]  y2_re,
    input logic signed [Y_W-1:0]  y2_im
);
    bit [1:0] age_q;
    bit       armed_q;

    always_ff @(posedge clk) begin
        armed_q <= armed_q | rst;
        if (rst)             age_q <= 2'd0;
        else if (age_q != 3) age_q <= age_q + 2'd1;
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (age_q == 3) |-> (out_vld == $past(in_vld, 3))); // R1

    AST_REAL_CENTRE: assert property (@(posedge clk) disable iff (rst)
        (age_q == 3) |-> ((int'(y1_re) + int'(y2_re)) == 2 * int'($past(a_re, 3)))); // R2

    AST_IMAG_CENTRE: assert property (@(posedge clk) disable iff (rst)
        (age_q == 3) |-> ((int'(y1_im) + int'(y2_im)) == 2 * int'($past(a_im, 3)))); // R3

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (age_q == 3) |-> ((int'(y1_re) - int'(y2_re)) >= -(2 ** T_W)
                       && (int'(y1_re) - int'(y2_re)) <= (2 ** T_W) - 2)); // R5

    AST_RESET_CLEARS: assert property (@(posedge clk)
        (armed_q && $past(rst)) |-> (!out_vld && y1_re == 0 && y1_im == 0
                                     && y2_re == 0 && y2_im == 0)); // R7
endmodule

bind twiddle_butterfly bfly_checker #(.X1_W(X1_W), .T_W(T_W), .Y_W(Y_W)) u_chk (
    .clk (clk), .rst (rst), .in_vld (in_vld), .a_re (a_re), .a_im (a_im),
    .out_vld (out_vld), .y1_re (y1_re), .y1_im (y1_im),
    .y2_re (y2_re), .y2_im (y2_im)
);

// File: tb/twiddle_butterfly_test.sv
module twiddle_butterfly_test;
    localparam int CLK_PERIOD = 10;
    localparam int WR   = 45;
    localparam int WI   = -45;
    localparam int FR   = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_vld = 1'b0;
    logic signed [15:0] a_re = '0, a_im = '0;
    logic signed [7:0]  b_re = '0, b_im = '0;
    logic out_vld;
    logic signed [16:0] y1_re, y1_im, y2_re, y2_im;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // model of what sits in stage 1, 2, 3 (stage 3 = outputs)
    int m_v[3], m_y1r[3], m_y1i[3], m_y2r[3], m_y2i[3];

    always #(CLK_PERIOD/2) clk = ~clk;

    twiddle_butterfly #(
        .X1_W(16), .X2_W(8), .TW_W(8), .FRAC(FR),
        .W_RE(8'(WR)), .W_IM(8'(WI))
    ) uut (
        .clk (clk), .rst (rst), .in_vld (in_vld),
        .a_re (a_re), .a_im (a_im), .b_re (b_re), .b_im (b_im),
        .out_vld (out_vld), .y1_re (y1_re), .y1_im (y1_im),
        .y2_re (y2_re), .y2_im (y2_im)
    );

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0d expected %0d at %0t", req, got, exp, $time);
        end
    endtask

    task automatic check_outputs();
        check("R1/R6/R8 out_vld", int'(out_vld), m_v[2]);
        check("R2/R4/R5 y1_re", int'(y1_re), m_y1r[2]);
        check("R2/R4/R5 y2_re", int'(y2_re), m_y2r[2]);
        check("R3/R4/R5 y1_im", int'(y1_im), m_y1i[2]);
        check("R3/R4/R5 y2_im", int'(y2_im), m_y2i[2]);
    endtask

    // one clock: check outputs, drive new operands, advance the model
    task automatic cycle(input bit r, input bit v, input int ar, input int ai,
                         input int br, input int bi);
        int tr, ti;
        check_outputs();
        rst    = r;
        in_vld = v;
        a_re   = 16'(ar);  a_im = 16'(ai);
        b_re   = 8'(br);   b_im = 8'(bi);
        tr = (WR * br - WI * bi) >>> FR;
        ti = (WR * bi + WI * br) >>> FR;
        for (int s = 2; s > 0; s--) begin
            m_v[s] = m_v[s-1]; m_y1r[s] = m_y1r[s-1]; m_y2r[s] = m_y2r[s-1];
            m_y1i[s] = m_y1i[s-1]; m_y2i[s] = m_y2i[s-1];
        end
        m_v[0] = int'(v);
        m_y1r[0] = ar + tr; m_y2r[0] = ar - tr;
        m_y1i[0] = ai + ti; m_y2i[0] = ai - ti;
        if (r) begin
            for (int s = 0; s < 3; s++) begin
                m_v[s] = 0; m_y1r[s] = 0; m_y2r[s] = 0; m_y1i[s] = 0; m_y2i[s] = 0;
            end
        end
        @(negedge clk);
    endtask

    function automatic int pick_a(input int i);
        int h;
        h = i * 1103515245 + 12345;
        case (i % 6)
            0: return -32768;
            1: return 32767;
            2: return 0;
            3: return -1;
            default: return int'($signed(h[23:8]));
        endcase
    endfunction

    initial begin
        for (int s = 0; s < 3; s++) begin
            m_v[s] = 0; m_y1r[s] = 0; m_y2r[s] = 0; m_y1i[s] = 0; m_y2i[s] = 0;
        end
        @(negedge clk);
        @(negedge clk);
        // R7: state straight after reset
        check("R7 out_vld after reset", int'(out_vld), 0);
        check("R7 y1_re after reset", int'(y1_re), 0);
        check("R7 y2_im after reset", int'(y2_im), 0);

        // R4: one small negative product, alone in the pipe
        cycle(1'b0, 1'b1, 0, 0, 0, 1);
        cycle(1'b0, 1'b0, 0, 0, 0, 0);
        cycle(1'b0, 1'b0, 0, 0, 0, 0);
        // y1_re = floor(45/64)=0 ; y1_im = floor(45/64)=0 ; the product is
        // W_re*b_im = 45 -> 0, W_im*b_re... use b_re=1,b_im=0 next for -45 -> -1
        cycle(1'b0, 1'b1, 0, 0, 1, 0);
        cycle(1'b0, 1'b0, 0, 0, 0, 0);
        cycle(1'b0, 1'b0, 0, 0, 0, 0);
        check("R4 floor of -45/64", int'(y1_im), -1);

        // R2 R3 R5 R6 R8: every b value, a through full-scale corners
        for (int i = 0; i < 65536; i++) begin
            cycle(1'b0, (i % 7) != 6, pick_a(i), pick_a(i + 3),
                  int'($signed(i[15:8])), int'($signed(i[7:0])));
        end

        // R7: reset with valid operands in flight
        cycle(1'b0, 1'b1, 1000, -1000, 127, -128);
        cycle(1'b0, 1'b1, -32768, 32767, -128, -128);
        cycle(1'b1, 1'b1, 5, 5, 5, 5);
        check("R7 out_vld cleared by reset", int'(out_vld), 0);
        check("R7 y1_re cleared by reset", int'(y1_re), 0);
        for (int i = 0; i < 4; i++) begin
            cycle(1'b0, 1'b0, 77, 77, 3, 3);
            check("R7 no result from flushed operands", int'(out_vld), 0);
        end
        cycle(1'b0, 1'b0, 0, 0, 0, 0);
        check_outputs();

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule